// File: doc/BRIEF.md
# Channel Gamma Lookup Stage

This block corrects the colour response of several display channels. A host loads one curve per colour of each channel into an internal table through two write ports: an address port that sets a write pointer (and chooses whether the pointer steps), and a data port that stores one 8-bit entry at the pointer. On the pixel side, each incoming RGB pixel carries a channel number. Each 8-bit component is replaced by the entry its value selects in that channel's table for that colour. When the channel's gamma-enable bit is clear, the component passes through unchanged, which is the same as a linear curve.

The table is addressed linearly. Channels come one after another. Each channel holds 256 red entries, then 256 green, then 256 blue, so channel c starts at c × 768. With the default three channels the address space is 2304 entries. The host port is a small state machine. **ST_IDLE** is the state after reset, in which no address has been set. **ST_FIXED** is entered by an address write with the step flag clear, and the pointer holds there. **ST_STREAM** is entered by an address write with the step flag set, and each data write advances the pointer. From any state, an address write is the only transition: *to ST_FIXED* when the flag is clear, *to ST_STREAM* when it is set. Nothing leads back to ST_IDLE except reset.

Top module: `gamma_lut_stage`

## Requirements
- R1: After reset, pix_out_valid is 0, host_ptr reads 0 and the host port is in ST_IDLE.
- R2: A data write made before any address write is discarded: host_ptr stays 0 and no entry changes.
- R3: Linear address a maps to channel a/768, colour (a mod 768)/256 (0 red, 1 green, 2 blue) and entry a mod 256, so channel c's red entry 0 sits at c × 768.
- R4: With host_addr_step = 1 at the address write, every later data write stores at the pointer and then advances it by one.
- R5: With host_addr_step = 0 at the address write, repeated data writes all land on that one address, the last one wins, and host_ptr does not move.
- R6: Stepping from the last address (2303) wraps to 0. An address write of 2304 or more sets the pointer to 0.
- R7: When gamma_en[c] is 1, each component of a pixel on channel c leaves as the table entry of that channel and colour, indexed by the component's value.
- R8: When gamma_en[c] is 0, the pixel leaves unchanged. The enable bit is sampled in the same cycle as the pixel.
- R9: pix_out_valid and pix_out_chan repeat pix_in_valid and pix_in_chan exactly two clock cycles later, whether the lookup is used or bypassed.
- R10: When an address write and a data write fall in the same cycle, the address write takes effect and the data write is dropped.
- R11: A pixel accepted in one cycle reads the table as it stood before a data write that lands on the next clock edge, even when that write targets the same entry.
- R12: A pixel whose channel number is NUM_CH or more passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_we | input | 1 | Load the write pointer |
| host_addr_wdata | input | 12 | New pointer value |
| host_addr_step | input | 1 | Step flag captured with the address |
| host_data_we | input | 1 | Store one table entry |
| host_data_wdata | input | 8 | Entry value |
| host_ptr | output | 12 | Current write pointer |
| gamma_en | input | 3 | Per-channel lookup enable |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in_chan | input | 2 | Input channel number |
| pix_in_r | input | 8 | Input red |
| pix_in_g | input | 8 | Input green |
| pix_in_b | input | 8 | Input blue |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out_chan | output | 2 | Output channel number |
| pix_out_r | output | 8 | Output red |
| pix_out_g | output | 8 | Output green |
| pix_out_b | output | 8 | Output blue |

## Verification
A table write and a pixel lookup of the very same entry can fall on the same clock edge. The bench provokes this by setting a fixed address on channel 0 red entry 10, sending a pixel with red = 10, and asserting the data write in the next cycle. The pixel must leave with the old entry, and a second pixel must show the new one. An address write and a data write in one cycle is the other collision: it is judged through host_ptr and by looking up both affected entries afterwards.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int COLOURS = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIXED  = 2'd1,
        ST_STREAM = 2'd2
    } host_state_e;
endpackage

// File: rtl/glut_table_bank.sv
module glut_table_bank #(
    parameter int ROWS  = 768,
    parameter int ROW_W = 10,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [DW-1:0]    wr_data,
    input  logic [ROW_W-1:0] rd_row,
    output logic [DW-1:0]    rd_data
);
    logic [DW-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_row] <= wr_data;
        end
    end

    // Read-before-write: the read sees the entry as of the last edge.
    assign rd_data = mem[rd_row];

    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(wr_row) < ROWS)); // R3
endmodule

// File: rtl/glut_host_port.sv
module glut_host_port
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int ADDR_W  = 12,
    parameter int ROW_W   = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_we,
    input  logic [ADDR_W-1:0]   addr_wdata,
    input  logic                addr_step,
    input  logic                data_we,
    input  logic [DW-1:0]       data_wdata,
    output logic [ADDR_W-1:0]   ptr_o,
    output logic [COLOURS-1:0]  wr_sel_o,
    output logic [ROW_W-1:0]    wr_row_o,
    output logic [DW-1:0]       wr_data_o
);
    localparam int SPAN  = COLOURS * ENTRIES;
    localparam int TOTAL = NUM_CH * SPAN;
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SPAN);
    localparam logic [ADDR_W-1:0] ENT_A  = ADDR_W'(ENTRIES);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(TOTAL - 1);

    host_state_e       state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              wr_en;
    logic [ADDR_W-1:0] ch_a, rem_a, col_a, idx_a, addr_legal;

    assign addr_legal = (int'(addr_wdata) < TOTAL) ? addr_wdata : '0;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next state and pointer
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_we) begin
                    state_d = addr_step ? ST_STREAM : ST_FIXED;
                    ptr_d   = addr_legal;
                end
            end
            ST_FIXED: begin
                if (addr_we) begin
                    state_d = addr_step ? ST_STREAM : ST_FIXED;
                    ptr_d   = addr_legal;
                end
            end
            ST_STREAM: begin
                if (addr_we) begin
                    state_d = addr_step ? ST_STREAM : ST_FIXED;
                    ptr_d   = addr_legal;
                end else if (data_we) begin
                    ptr_d = (ptr_q == LAST_A) ? '0 : ptr_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                ptr_d   = '0;
            end
        endcase
    end

    // Outputs: write strobe and address decode
    always_comb begin
        wr_en = 1'b0;
        unique case (state_q)
            ST_IDLE:   wr_en = 1'b0;
            ST_FIXED:  wr_en = data_we && !addr_we;
            ST_STREAM: wr_en = data_we && !addr_we;
            default:   wr_en = 1'b0;
        endcase
        ch_a  = ptr_q / SPAN_A;
        rem_a = ptr_q % SPAN_A;
        col_a = rem_a / ENT_A;
        idx_a = rem_a % ENT_A;
    end

    assign wr_row_o  = ROW_W'(ch_a * ENT_A + idx_a);
    assign wr_data_o = data_wdata;
    assign ptr_o     = ptr_q;

    for (genvar c = 0; c < COLOURS; c++) begin : g_sel
        assign wr_sel_o[c] = wr_en && (col_a == ADDR_W'(c));
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr_q) < TOTAL); // R6
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (wr_sel_o == '0)); // R2
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED && !addr_we) |=> $stable(ptr_q)); // R5
    AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && data_we && !addr_we && ptr_q != LAST_A)
        |=> (ptr_q == $past(ptr_q) + 1'b1)); // R4
    AST_ADDR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && data_we) |-> (wr_sel_o == '0)); // R10
endmodule

// File: rtl/glut_pixel_pipe.sv
module glut_pixel_pipe
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ENTRIES = 256,
    parameter int DW      = 8,
    parameter int CH_W    = 2,
    parameter int ROW_W   = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic [CH_W-1:0]                   in_chan,
    input  logic [COLOURS-1:0][DW-1:0]        in_pix,
    input  logic [NUM_CH-1:0]                 gamma_en,
    output logic [COLOURS-1:0][ROW_W-1:0]     rd_row_o,
    input  logic [COLOURS-1:0][DW-1:0]        lut_i,
    output logic                              out_valid,
    output logic [CH_W-1:0]                   out_chan,
    output logic [COLOURS-1:0][DW-1:0]        out_pix
);
    logic                       valid_s1;
    logic [CH_W-1:0]            chan_s1;
    logic                       en_s1;
    logic                       chan_ok_s1;
    logic [COLOURS-1:0][DW-1:0] pix_s1;
    logic                       en_in;
    logic [1:0]                 warm_q;

    assign en_in = (int'(in_chan) < NUM_CH) ? gamma_en[in_chan] : 1'b0;

    // Stage 1: capture pixel, channel and its enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s1   <= 1'b0;
            chan_s1    <= '0;
            en_s1      <= 1'b0;
            chan_ok_s1 <= 1'b0;
            pix_s1     <= '0;
        end else begin
            valid_s1   <= in_valid;
            chan_s1    <= in_chan;
            en_s1      <= en_in;
            chan_ok_s1 <= (int'(in_chan) < NUM_CH);
            pix_s1     <= in_pix;
        end
    end

    // Stage 2: table read and select
    for (genvar c = 0; c < COLOURS; c++) begin : g_col
        assign rd_row_o[c] = chan_ok_s1
            ? ROW_W'(int'(chan_s1) * ENTRIES + int'(pix_s1[c])) : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_pix[c] <= '0;
            end else begin
                out_pix[c] <= en_s1 ? lut_i[c] : pix_s1[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
        end else begin
            out_valid <= valid_s1;
            out_chan  <= chan_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R9
    AST_CHAN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && out_valid) |-> (out_chan == $past(in_chan, 2))); // R9
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_s1 && !en_s1) |=> (out_pix == $past(pix_s1))); // R8
    AST_BAD_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_chan) >= NUM_CH) |=> !en_s1); // R12
endmodule

// File: rtl/gamma_lut_stage.sv
module gamma_lut_stage
    import gamma_lut_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    localparam int ENTRIES = 1 << DW,
    localparam int TOTAL   = NUM_CH * COLOURS * ENTRIES,
    localparam int ADDR_W  = $clog2(TOTAL),
    localparam int ROWS    = NUM_CH * ENTRIES,
    localparam int ROW_W   = $clog2(ROWS),
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr_we,
    input  logic [ADDR_W-1:0] host_addr_wdata,
    input  logic              host_addr_step,
    input  logic              host_data_we,
    input  logic [DW-1:0]     host_data_wdata,
    output logic [ADDR_W-1:0] host_ptr,
    input  logic [NUM_CH-1:0] gamma_en,
    input  logic              pix_in_valid,
    input  logic [CH_W-1:0]   pix_in_chan,
    input  logic [DW-1:0]     pix_in_r,
    input  logic [DW-1:0]     pix_in_g,
    input  logic [DW-1:0]     pix_in_b,
    output logic              pix_out_valid,
    output logic [CH_W-1:0]   pix_out_chan,
    output logic [DW-1:0]     pix_out_r,
    output logic [DW-1:0]     pix_out_g,
    output logic [DW-1:0]     pix_out_b
);
    logic [COLOURS-1:0]            wr_sel;
    logic [ROW_W-1:0]              wr_row;
    logic [DW-1:0]                 wr_data;
    logic [COLOURS-1:0][ROW_W-1:0] rd_row;
    logic [COLOURS-1:0][DW-1:0]    lut_data;
    logic [COLOURS-1:0][DW-1:0]    pix_in_arr;
    logic [COLOURS-1:0][DW-1:0]    pix_out_arr;

    assign pix_in_arr[0] = pix_in_r;
    assign pix_in_arr[1] = pix_in_g;
    assign pix_in_arr[2] = pix_in_b;
    assign pix_out_r = pix_out_arr[0];
    assign pix_out_g = pix_out_arr[1];
    assign pix_out_b = pix_out_arr[2];

    glut_host_port #(
        .NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW),
        .ADDR_W(ADDR_W), .ROW_W(ROW_W)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (host_addr_we),
        .addr_wdata (host_addr_wdata),
        .addr_step  (host_addr_step),
        .data_we    (host_data_we),
        .data_wdata (host_data_wdata),
        .ptr_o      (host_ptr),
        .wr_sel_o   (wr_sel),
        .wr_row_o   (wr_row),
        .wr_data_o  (wr_data)
    );

    for (genvar c = 0; c < COLOURS; c++) begin : g_bank
        glut_table_bank #(.ROWS(ROWS), .ROW_W(ROW_W), .DW(DW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_sel[c]),
            .wr_row  (wr_row),
            .wr_data (wr_data),
            .rd_row  (rd_row[c]),
            .rd_data (lut_data[c])
        );
    end

    glut_pixel_pipe #(
        .NUM_CH(NUM_CH), .ENTRIES(ENTRIES), .DW(DW),
        .CH_W(CH_W), .ROW_W(ROW_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_in_valid),
        .in_chan   (pix_in_chan),
        .in_pix    (pix_in_arr),
        .gamma_en  (gamma_en),
        .rd_row_o  (rd_row),
        .lut_i     (lut_data),
        .out_valid (pix_out_valid),
        .out_chan  (pix_out_chan),
        .out_pix   (pix_out_arr)
    );

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R3
endmodule

// File: tb/gamma_lut_stage_bench.sv
`timescale 1ns/1ps
module gamma_lut_stage_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_addr_we = 1'b0;
    logic [11:0] host_addr_wdata = '0;
    logic        host_addr_step = 1'b0;
    logic        host_data_we = 1'b0;
    logic [7:0]  host_data_wdata = '0;
    logic [11:0] host_ptr;
    logic [2:0]  gamma_en = '0;
    logic        pix_in_valid = 1'b0;
    logic [1:0]  pix_in_chan = '0;
    logic [7:0]  pix_in_r = '0, pix_in_g = '0, pix_in_b = '0;
    logic        pix_out_valid;
    logic [1:0]  pix_out_chan;
    logic [7:0]  pix_out_r, pix_out_g, pix_out_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gamma_lut_stage u_gamma_lut_stage (
        .clk(clk), .rst_n(rst_n),
        .host_addr_we(host_addr_we), .host_addr_wdata(host_addr_wdata),
        .host_addr_step(host_addr_step), .host_data_we(host_data_we),
        .host_data_wdata(host_data_wdata), .host_ptr(host_ptr),
        .gamma_en(gamma_en), .pix_in_valid(pix_in_valid),
        .pix_in_chan(pix_in_chan), .pix_in_r(pix_in_r),
        .pix_in_g(pix_in_g), .pix_in_b(pix_in_b),
        .pix_out_valid(pix_out_valid), .pix_out_chan(pix_out_chan),
        .pix_out_r(pix_out_r), .pix_out_g(pix_out_g), .pix_out_b(pix_out_b)
    );

    function automatic int curve(int ch, int col, int i);
        return (i * (2 * (ch * 3 + col) + 1) + ch * 7 + col * 13) & 255;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic addr_write(input int a, input bit step);
        @(negedge clk);
        host_addr_we = 1'b1; host_addr_wdata = 12'(a); host_addr_step = step;
        @(negedge clk);
        host_addr_we = 1'b0;
    endtask

    task automatic data_write(input int v);
        @(negedge clk);
        host_data_we = 1'b1; host_data_wdata = 8'(v);
        @(negedge clk);
        host_data_we = 1'b0;
    endtask

    // Drive one pixel, sample two edges later.
    task automatic pix(input string req, input int ch, input int r, input int g,
                       input int b, input int er, input int eg, input int eb);
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_chan = 2'(ch);
        pix_in_r = 8'(r); pix_in_g = 8'(g); pix_in_b = 8'(b);
        @(negedge clk);
        pix_in_valid = 1'b0;
        if (pix_out_valid) chk("R9 early valid", 1, 0);
        @(negedge clk);
        chk({req, " valid"}, int'(pix_out_valid), 1);
        chk({req, " chan"}, int'(pix_out_chan), ch);
        chk({req, " rgb"}, {8'h0, pix_out_r, pix_out_g, pix_out_b},
            {8'h0, 8'(er), 8'(eg), 8'(eb)});
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out valid", int'(pix_out_valid), 0);
        chk("R1 ptr", int'(host_ptr), 0);
        // R2 data write before any address write
        data_write(8'hAA);
        chk("R2 ptr after idle write", int'(host_ptr), 0);

        // R4 R3 fill whole table in one stepping burst
        addr_write(0, 1'b1);
        for (int a = 0; a < 2304; a++) begin
            @(negedge clk);
            if (a == 768) chk("R3 ch1 base", int'(host_ptr), 768);
            host_data_we = 1'b1;
            host_data_wdata = 8'(curve(a / 768, (a % 768) / 256, a % 256));
        end
        @(negedge clk);
        host_data_we = 1'b0;
        chk("R6 wrap after full burst", int'(host_ptr), 0);

        // R7 sweep all channels with lookup on
        gamma_en = 3'b111;
        for (int ch = 0; ch < 3; ch++) begin
            for (int i = 0; i < 256; i++) begin
                pix("R7 lookup", ch, i, 255 - i, i ^ 8'h5A,
                    curve(ch, 0, i), curve(ch, 1, 255 - i), curve(ch, 2, i ^ 8'h5A));
            end
        end

        // R8 bypass sweep on channel 1
        gamma_en = 3'b101;
        for (int i = 0; i < 256; i++) begin
            pix("R8 bypass", 1, i, 255 - i, i ^ 8'h5A, i, 255 - i, i ^ 8'h5A);
        end
        // R8 enable sampled with the pixel
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_chan = 2'd1;
        pix_in_r = 8'd3; pix_in_g = 8'd4; pix_in_b = 8'd5;
        @(negedge clk);
        pix_in_valid = 1'b0; gamma_en = 3'b111;
        @(negedge clk);
        chk("R8 enable sampled with pixel", {8'h0, pix_out_r, pix_out_g, pix_out_b},
            {8'h0, 8'd3, 8'd4, 8'd5});
        gamma_en = 3'b101;

        // R12 out-of-range channel passes through
        pix("R12 chan 3", 3, 8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56);

        // R5 fixed address, last write wins
        addr_write(2 * 768 + 256 + 5, 1'b0);
        data_write(8'h11);
        data_write(8'h22);
        data_write(8'h33);
        chk("R5 ptr holds", int'(host_ptr), 2 * 768 + 256 + 5);
        pix("R5 last wins", 2, 0, 5, 0, curve(2, 0, 0), 8'h33, curve(2, 2, 0));
        pix("R5 neighbour", 2, 0, 6, 0, curve(2, 0, 0), curve(2, 1, 6), curve(2, 2, 0));

        // R4 step from channel 1 base
        gamma_en = 3'b111;
        addr_write(768, 1'b1);
        data_write(8'hC3);
        chk("R4 ptr stepped", int'(host_ptr), 769);
        pix("R4 stored at base", 1, 0, 0, 0, 8'hC3, curve(1, 1, 0), curve(1, 2, 0));

        // R6 wrap from last and out-of-range address
        addr_write(2303, 1'b1);
        data_write(8'h44);
        chk("R6 wrap from last", int'(host_ptr), 0);
        pix("R6 last entry", 2, 0, 0, 255, curve(2, 0, 0), curve(2, 1, 0), 8'h44);
        addr_write(7, 1'b1);
        chk("R6 ptr set 7", int'(host_ptr), 7);
        addr_write(3000, 1'b1);
        chk("R6 out of range addr", int'(host_ptr), 0);

        // R10 address and data in the same cycle
        addr_write(100, 1'b1);
        @(negedge clk);
        host_addr_we = 1'b1; host_addr_wdata = 12'd200; host_addr_step = 1'b1;
        host_data_we = 1'b1; host_data_wdata = 8'h99;
        @(negedge clk);
        host_addr_we = 1'b0; host_data_we = 1'b0;
        chk("R10 ptr from address", int'(host_ptr), 200);
        pix("R10 entry 100 kept", 0, 100, 0, 0, curve(0, 0, 100), curve(0, 1, 0), curve(0, 2, 0));
        pix("R10 entry 200 kept", 0, 200, 0, 0, curve(0, 0, 200), curve(0, 1, 0), curve(0, 2, 0));

        // R11 lookup and write of the same entry on adjacent edges
        addr_write(10, 1'b0);
        @(negedge clk);
        pix_in_valid = 1'b1; pix_in_chan = 2'd0;
        pix_in_r = 8'd10; pix_in_g = 8'd0; pix_in_b = 8'd0;
        @(negedge clk);
        pix_in_valid = 1'b0;
        host_data_we = 1'b1; host_data_wdata = 8'h77;
        @(negedge clk);
        host_data_we = 1'b0;
        chk("R11 old value seen", int'(pix_out_r), curve(0, 0, 10));
        pix("R11 new value later", 0, 10, 0, 0, 8'h77, curve(0, 1, 0), curve(0, 2, 0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule